// File: doc/BRIEF.md
# USB Host Command Register Controller

This block holds the 16-bit command register of a full/low-speed USB host controller, together with the logic that acts on its bits. Software writes and reads the register through a simple write-enable/data port. The rest of the controller sees the outcome as decoded control levels: whether a new transaction may start, whether the controller is halted, whether resume signalling should be driven on the bus, whether a low-speed EOP is wanted, and whether the global reset is in force.

The register is not a plain store, because hardware changes some of its bits. In software debug mode the run bit clears itself after each finished transaction, so the scheduler steps one transaction at a time. While the controller is suspended, a resume event sets the resume bit. When software clears the resume bit, the bit keeps reading as 1 until the line logic reports that the EOP is done.

The bit positions are: 0 run, 2 global reset, 3 suspend, 4 force resume, 5 software debug, 6 configure flag, 7 max packet, 8 loopback. Bit 1 and bits 15:9 are reserved. A write takes effect on the next rising clock edge.

Top module: `hc_command_ctrl`

## Requirements
- R1: After reset `rdData` reads 0x0000. Bit 1 and bits 15:9 always read 0. `halted` is 1 and `eopReq`, `globalReset` and `resumeDrive` are 0.
- R2: Bits 8 (loopback), 7 (max packet, 1 = 64 bytes) and 6 (configure flag) read back as last written. `loopbackEn` and `maxPkt64` follow bits 8 and 7. Bit 6 changes no output other than `rdData`.
- R3: A write updates bit 5 (software debug) only if `halted` was 1 in the cycle of the write. Otherwise bit 5 keeps its value.
- R4: While bit 5 is 1, a `xferDone` pulse clears bit 0 (run) on the next edge, unless a register write occurs in the same cycle.
- R5: `halted` is 1 exactly when bit 0 is 0 and no transaction is in flight. A transaction is in flight from a `txnStart` accepted while `txnAllowed` is 1 until the next `xferDone`.
- R6: `txnAllowed` is 1 only when bit 0 is 1, bit 3 (suspend) is 0 and bit 2 (global reset) is 0.
- R7: If bit 3 is 1 and `resumeEvt` is high, bit 4 is set on the next edge. `resumeDrive` is 1 while bit 4 is 1 and no EOP request is pending.
- R8: A write of 0 to bit 4 while it reads 1 raises `eopReq`. Bit 4 keeps reading 1 until `eopDone` is seen while `eopReq` is high. Then bit 4 and `eopReq` clear on the next edge.
- R9: A write that clears bit 3 and bit 4 together clears bit 3 on the next edge, even though bit 4 stays set until the EOP completes.
- R10: A write with bit 2 set loads 0x0004 whatever the other data bits are. It asserts `globalReset` and drops any pending EOP request and any in-flight transaction. A later write with bit 2 clear releases the reset.
- R11: A write to bit 0 sets or clears run. A write takes priority over the debug auto-clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read value |
| txnStart | input | 1 | Scheduler starts a transaction |
| xferDone | input | 1 | Current transaction has completed |
| resumeEvt | input | 1 | Resume event detected on the bus |
| eopDone | input | 1 | Low-speed EOP has been sent |
| txnAllowed | output | 1 | A new transaction may be started |
| halted | output | 1 | Run clear and nothing in flight |
| resumeDrive | output | 1 | Drive global resume signalling |
| eopReq | output | 1 | Request a low-speed EOP |
| globalReset | output | 1 | Global reset to bus and controller |
| loopbackEn | output | 1 | Loopback test mode enable |
| maxPkt64 | output | 1 | Reclamation packet limit is 64 bytes |

## Verification
The hardest state to reach is the EOP handoff. It needs four things in order: suspend entered, a resume event while suspended, a write that clears the resume bit, and `eopDone` arriving late, possibly together with another resume event or a global reset. Debug single-stepping is nearly as hard, because the debug bit can only be written while halted, and the run bit then has to be set before a transaction can start. Directed sequences walk both paths once. Biased random traffic then keeps suspend set for long stretches and drops in rare global-reset writes, so that these states meet in many combinations against a cycle model in the bench.

// File: rtl/hc_cmd_pkg.sv
`timescale 1ns/1ps
package hc_cmd_pkg;
  localparam int RUN_B  = 0;
  localparam int GRST_B = 2;
  localparam int SUSP_B = 3;
  localparam int RSM_B  = 4;
  localparam int DBG_B  = 5;
  localparam int CFG_B  = 6;
  localparam int MPKT_B = 7;
  localparam int LOOP_B = 8;
  localparam int USED_W = LOOP_B + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic grstLoad;
    logic regWrite;
    logic dbgWrOk;
    logic runClr;
    logic fgrSet;
    logic fgrClr;
  } cmdStrobe_t;

  // stored command bits
  typedef struct packed {
    logic loop;
    logic maxPkt;
    logic cfgFlag;
    logic swDbg;
    logic resume;
    logic suspend;
    logic gReset;
    logic run;
  } cmdBits_t;
endpackage

// File: rtl/hc_cmd_dp.sv
`timescale 1ns/1ps
module hc_cmd_dp
  import hc_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output cmdBits_t          bits,
  output logic [DATA_W-1:0] rdData
);
  cmdBits_t bitsNext;
  logic     unusedWr;

  assign unusedWr = ^{wrData[DATA_W-1:USED_W], wrData[1], wrData[GRST_B]};

  always_comb begin
    bitsNext = bits;
    if (strobe.grstLoad) begin
      bitsNext        = '0;
      bitsNext.gReset = 1'b1;
    end else begin
      if (strobe.regWrite) begin
        bitsNext.run     = wrData[RUN_B];
        bitsNext.gReset  = 1'b0;
        bitsNext.suspend = wrData[SUSP_B];
        bitsNext.cfgFlag = wrData[CFG_B];
        bitsNext.maxPkt  = wrData[MPKT_B];
        bitsNext.loop    = wrData[LOOP_B];
        if (strobe.dbgWrOk) bitsNext.swDbg = wrData[DBG_B];
        if (!bits.resume && wrData[RSM_B]) bitsNext.resume = 1'b1;
      end else if (strobe.runClr) begin
        bitsNext.run = 1'b0;
      end
      if (strobe.fgrSet)      bitsNext.resume = 1'b1;
      else if (strobe.fgrClr) bitsNext.resume = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bits <= '0;
    else       bits <= bitsNext;
  end

  always_comb begin
    rdData         = '0;
    rdData[RUN_B]  = bits.run;
    rdData[GRST_B] = bits.gReset;
    rdData[SUSP_B] = bits.suspend;
    rdData[RSM_B]  = bits.resume;
    rdData[DBG_B]  = bits.swDbg;
    rdData[CFG_B]  = bits.cfgFlag;
    rdData[MPKT_B] = bits.maxPkt;
    rdData[LOOP_B] = bits.loop;
  end
endmodule

// File: rtl/hc_cmd_ctl.sv
`timescale 1ns/1ps
module hc_cmd_ctl
  import hc_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrGrst,
  input  logic       wrResume,
  input  logic       txnStart,
  input  logic       xferDone,
  input  logic       resumeEvt,
  input  logic       eopDone,
  input  cmdBits_t   bits,
  output cmdStrobe_t strobe,
  output logic       txnAllowed,
  output logic       halted,
  output logic       resumeDrive,
  output logic       eopReq,
  output logic       globalReset
);
  logic eopPend;
  logic inFlight;

  assign halted      = !bits.run && !inFlight;
  assign txnAllowed  = bits.run && !bits.suspend && !bits.gReset;
  assign resumeDrive = bits.resume && !eopPend;
  assign eopReq      = eopPend;
  assign globalReset = bits.gReset;

  always_comb begin
    strobe          = '0;
    strobe.grstLoad = wrEn && wrGrst;
    strobe.regWrite = wrEn && !wrGrst;
    strobe.dbgWrOk  = halted;
    strobe.runClr   = xferDone && bits.swDbg;
    strobe.fgrSet   = bits.suspend && resumeEvt;
    strobe.fgrClr   = eopPend && eopDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eopPend  <= 1'b0;
      inFlight <= 1'b0;
    end else if (strobe.grstLoad) begin
      eopPend  <= 1'b0;
      inFlight <= 1'b0;
    end else begin
      if (eopPend && eopDone)
        eopPend <= 1'b0;
      else if (strobe.regWrite && bits.resume && !wrResume)
        eopPend <= 1'b1;

      if (txnStart && txnAllowed) inFlight <= 1'b1;
      else if (xferDone)          inFlight <= 1'b0;
    end
  end
endmodule

// File: rtl/hc_command_ctrl.sv
`timescale 1ns/1ps
module hc_command_ctrl
  import hc_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              txnStart,
  input  logic              xferDone,
  input  logic              resumeEvt,
  input  logic              eopDone,
  output logic              txnAllowed,
  output logic              halted,
  output logic              resumeDrive,
  output logic              eopReq,
  output logic              globalReset,
  output logic              loopbackEn,
  output logic              maxPkt64
);
  cmdStrobe_t strobe;
  cmdBits_t   bits;

  hc_cmd_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrGrst     (wrData[GRST_B]),
    .wrResume   (wrData[RSM_B]),
    .txnStart   (txnStart),
    .xferDone   (xferDone),
    .resumeEvt  (resumeEvt),
    .eopDone    (eopDone),
    .bits       (bits),
    .strobe     (strobe),
    .txnAllowed (txnAllowed),
    .halted     (halted),
    .resumeDrive(resumeDrive),
    .eopReq     (eopReq),
    .globalReset(globalReset)
  );

  hc_cmd_dp #(.DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(wrData),
    .bits  (bits),
    .rdData(rdData)
  );

  assign loopbackEn = bits.loop;
  assign maxPkt64   = bits.maxPkt;
endmodule

// File: rtl/hc_cmd_chk.sv
`timescale 1ns/1ps
module hc_cmd_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              xferDone,
  input logic              resumeEvt,
  input logic              eopDone,
  input logic              txnAllowed,
  input logic              halted,
  input logic              eopReq,
  input logic              globalReset
);
  // R8
  eop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    eopReq |-> rdData[4]);

  // R8
  eop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    eopReq && eopDone |=> !eopReq);

  // R10
  greset_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[2] |=> globalReset && (rdData == 16'h0004) && !eopReq);

  // R4
  dbg_autoclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone && rdData[5] && !wrEn |=> !rdData[0]);

  // R6
  txn_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    txnAllowed |-> rdData[0] && !rdData[3] && !globalReset);

  // R3
  dbg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !wrData[2] && !halted |=> rdData[5] == $past(rdData[5]));

  // R7
  resume_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[3] && resumeEvt && !(wrEn && wrData[2]) |=> rdData[4]);
endmodule

bind hc_command_ctrl hc_cmd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData),
  .xferDone   (xferDone),
  .resumeEvt  (resumeEvt),
  .eopDone    (eopDone),
  .txnAllowed (txnAllowed),
  .halted     (halted),
  .eopReq     (eopReq),
  .globalReset(globalReset)
);

// File: tb/sim_hc_command_ctrl.sv
`timescale 1ns/1ps
module sim_hc_command_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        txnStart = 1'b0, xferDone = 1'b0, resumeEvt = 1'b0, eopDone = 1'b0;
  logic        txnAllowed, halted, resumeDrive, eopReq, globalReset, loopbackEn, maxPkt64;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model of the register state
  bit mRun, mGrst, mSusp, mRsm, mDbg, mCfg, mMpkt, mLoop, mPend, mFly;

  always #2.5 clk = ~clk;

  hc_command_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .txnStart(txnStart), .xferDone(xferDone), .resumeEvt(resumeEvt), .eopDone(eopDone),
    .txnAllowed(txnAllowed), .halted(halted), .resumeDrive(resumeDrive), .eopReq(eopReq),
    .globalReset(globalReset), .loopbackEn(loopbackEn), .maxPkt64(maxPkt64)
  );

  function automatic logic [15:0] expRd();
    return {7'b0, mLoop, mMpkt, mCfg, mDbg, mRsm, mSusp, mGrst, 1'b0, mRun};
  endfunction
  function automatic bit expHalted();   return !mRun && !mFly; endfunction
  function automatic bit expAllowed();  return mRun && !mSusp && !mGrst; endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R1/R2 rdData", rdData, expRd());
    chk("R5 halted", halted, expHalted());
    chk("R6 txnAllowed", txnAllowed, expAllowed());
    chk("R8 eopReq", eopReq, mPend);
    chk("R7 resumeDrive", resumeDrive, mRsm && !mPend);
    chk("R10 globalReset", globalReset, mGrst);
    chk("R2 loopbackEn", loopbackEn, mLoop);
    chk("R2 maxPkt64", maxPkt64, mMpkt);
  endtask

  task automatic step(bit we, logic [15:0] wd, bit ts, bit xd, bit re, bit ed);
    bit h, al, nRun, nGrst, nSusp, nRsm, nDbg, nCfg, nMpkt, nLoop, nPend, nFly;
    @(negedge clk);
    wrEn = we; wrData = wd; txnStart = ts; xferDone = xd; resumeEvt = re; eopDone = ed;
    h = expHalted(); al = expAllowed();
    if (we && wd[2]) begin
      {nRun, nSusp, nRsm, nDbg, nCfg, nMpkt, nLoop, nPend, nFly} = '0;
      nGrst = 1'b1;
    end else begin
      nRun  = we ? wd[0] : ((xd && mDbg) ? 1'b0 : mRun);      // R4 R11
      nGrst = we ? 1'b0 : mGrst;
      nSusp = we ? wd[3] : mSusp;                               // R9
      nDbg  = (we && h) ? wd[5] : mDbg;                         // R3
      nCfg  = we ? wd[6] : mCfg;
      nMpkt = we ? wd[7] : mMpkt;
      nLoop = we ? wd[8] : mLoop;
      if (mSusp && re)          nRsm = 1'b1;                    // R7
      else if (mPend && ed)     nRsm = 1'b0;                    // R8
      else if (we && !mRsm && wd[4]) nRsm = 1'b1;
      else                      nRsm = mRsm;
      if (mPend && ed)          nPend = 1'b0;
      else if (we && mRsm && !wd[4]) nPend = 1'b1;
      else                      nPend = mPend;
      if (ts && al)             nFly = 1'b1;
      else if (xd)              nFly = 1'b0;
      else                      nFly = mFly;
    end
    @(posedge clk);
    {mRun, mGrst, mSusp, mRsm, mDbg, mCfg, mMpkt, mLoop, mPend, mFly} =
      {nRun, nGrst, nSusp, nRsm, nDbg, nCfg, nMpkt, nLoop, nPend, nFly};
    #1;
    compareAll();
  endtask

  task automatic idle(); step(0, 16'h0, 0, 0, 0, 0); endtask
  task automatic wr(logic [15:0] d); step(1, d, 0, 0, 0, 0); endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit we, ts, xd, re, ed;
    logic [15:0] wd;
    void'($urandom(32'h5eed_1234));
    {mRun, mGrst, mSusp, mRsm, mDbg, mCfg, mMpkt, mLoop, mPend, mFly} = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset rdData", rdData, 16'h0000);
    chk("R1 reset halted", halted, 1);
    chk("R1 reset eopReq", eopReq, 0);
    @(negedge clk) rstN = 1'b1;
    idle();

    // R2 loop/maxp/cfg, reserved bits and bit 1 stay zero
    wr(16'hFFC2 & ~16'h003C);
    chk("R2 readback", rdData, 16'h01C0);
    chk("R2 loopbackEn", loopbackEn, 1);
    chk("R2 maxPkt64", maxPkt64, 1);
    chk("R1 reserved zero", rdData & 16'hFE02, 0);
    wr(16'h0040);
    chk("R2 cfg only", rdData, 16'h0040);
    chk("R2 cfg no effect halted", halted, 1);
    chk("R2 cfg no effect allowed", txnAllowed, 0);

    // R3 debug write while halted, then locked while running
    wr(16'h0020);
    chk("R3 dbg accepted", rdData, 16'h0020);
    wr(16'h0021);
    chk("R11 run set", rdData, 16'h0021);
    wr(16'h0001);
    chk("R3 dbg ignored not halted", rdData, 16'h0021);
    wr(16'h0021);

    // R5 R4 single step
    step(0, 16'h0, 1, 0, 0, 0);
    chk("R5 in flight", halted, 0);
    idle();
    step(0, 16'h0, 0, 1, 0, 0);
    chk("R4 run auto-cleared", rdData[0], 0);
    chk("R5 halted after done", halted, 1);

    // R11 write beats auto-clear
    wr(16'h0021);
    step(1, 16'h0021, 0, 1, 0, 0);
    chk("R11 write wins", rdData[0], 1);
    wr(16'h0000);

    // R6 R7 R8 R9 suspend / resume / EOP
    wr(16'h0008);
    chk("R6 no txn in suspend", txnAllowed, 0);
    step(0, 16'h0, 0, 0, 1, 0);
    chk("R7 resume set", rdData, 16'h0018);
    chk("R7 resumeDrive", resumeDrive, 1);
    wr(16'h0000);
    chk("R9 suspend cleared", rdData, 16'h0010);
    chk("R8 eopReq raised", eopReq, 1);
    chk("R7 resumeDrive off in EOP", resumeDrive, 0);
    idle(); idle();
    chk("R8 resume held", rdData[4], 1);
    step(0, 16'h0, 0, 0, 0, 1);
    chk("R8 resume cleared", rdData, 16'h0000);
    chk("R8 eopReq dropped", eopReq, 0);

    // R10 global reset
    wr(16'h0008); step(0, 16'h0, 0, 0, 1, 0); wr(16'h0000);
    wr(16'h01FD);
    chk("R10 reset value", rdData, 16'h0004);
    chk("R10 globalReset", globalReset, 1);
    chk("R10 eop dropped", eopReq, 0);
    wr(16'h0000);
    chk("R10 released", globalReset, 0);

    // biased random traffic
    for (int i = 0; i < 4000; i++) begin
      we = ($urandom % 4) == 0;
      wd = 16'($urandom);
      if (($urandom % 20) != 0) wd[2] = 1'b0;
      if (($urandom % 3) != 0) wd[3] = mSusp;
      ts = ($urandom % 3) == 0;
      xd = ($urandom % 4) == 0;
      re = ($urandom % 6) == 0;
      ed = ($urandom % 4) == 0;
      step(we, wd, ts, xd, re, ed);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule